// File: doc/BRIEF.md
# Indirect Lookup Table Access Port

This block is the register front end of a lookup table whose entries are wider than the 32-bit bus. Software never addresses an entry directly. It moves an entry through three staging word registers and one table-command register. If software writes an index with the commit flag clear, the addressed entry is copied into the staging words, where the next bus read can see it. If software writes an index with the commit flag set, the staging words are stored into that entry. The words are ordered most-significant first. Word 0 holds the entry bits from 64 upward, word 1 holds bits 63:32, and word 2 holds bits 31:0. In each entry, bits 61:60 are the entry-type field (0 = free), bits 59:48 carry a VLAN id, and bits 47:0 carry a MAC address with its first byte in bits 47:40.

A control register holds an enable bit and a self-clearing clear strobe. The clear strobe starts a sweep that writes every entry to all zeros, which leaves its type free. The same sweep runs automatically after reset. A status register reports the table size in units of 1024 entries and a busy flag while a sweep is running. The sweep is run by a two-state machine in `lut_ip_sweep`:
- ST_SWEEP is the state entered from reset.
- ST_SWEEP moves to ST_IDLE once the last index has been zeroed.
- ST_IDLE moves back to ST_SWEEP on an accepted clear strobe.

Register offsets (byte addresses):

| Offset | Register | Bits |
|---|---|---|
| 0x04 | status | [4:0] size in units of 1024 entries, [31] busy |
| 0x08 | control | [0] enable, [1] clear strobe (reads as 0) |
| 0x20 | table command | [15:0] index, [31] commit flag |
| 0x34 | word 0 | entry bits from 64 upward |
| 0x38 | word 1 | entry bits 63:32 |
| 0x3C | word 2 | entry bits 31:0 |

Top module: `lut_indirect_port`

## Requirements
- R1: After reset, `tbl_enable` is 0 and `tbl_busy` is 1. When the sweep that follows reset ends, every entry reads as all zeros.
- R2: Writes to offsets 0x34, 0x38 and 0x3C load staging words 0, 1 and 2. Word 0 keeps only its low ENTRY_W-64 bits, and its upper bits read as 0. Words 1 and 2 read back all 32 bits.
- R3: A write to offset 0x20 with bit 31 clear and an index below DEPTH in bits 15:0 loads the entry into the words. Entry bits 31:0 go to word 2, bits 63:32 to word 1, and the bits from 64 upward to word 0. A bus read on the next cycle returns the new value.
- R4: A write to offset 0x20 with bit 31 set and an index below DEPTH stores {word 0, word 1, word 2} into that entry. A fetch issued on the very next cycle returns it.
- R5: A commit whose index is at or above DEPTH changes no entry. A fetch whose index is at or above DEPTH sets all three words to zero.
- R6: Writing 1 to control bit 1 while idle starts a clear sweep. `tbl_busy` and status bit 31 are 1 for exactly DEPTH cycles. Afterwards every entry is zero, so its type field (entry bits 61:60, which are word 1 bits 29:28) reads 0, meaning free.
- R7: While a sweep runs, fetches and commits are ignored and the staging words keep their value. A further clear strobe neither restarts nor lengthens the sweep.
- R8: Status bits 4:0 read DEPTH/1024.
- R9: Control bit 0 is readable and writable and drives `tbl_enable`. Control bit 1 reads as 0.
- R10: Reads of any offset other than 0x04, 0x08 and 0x34–0x3C, including 0x20, return 0. Read data is registered and appears on the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tbl_enable | output | 1 | Enable bit from the control register |
| tbl_busy | output | 1 | Clear sweep in progress |

## Verification
Every entry is committed with its own arithmetic pattern and then fetched back in descending order. The pattern changes in every word, so a swapped word order, a wrong index slice or an aliased entry shows up as a mismatch. The first fetch follows its commit directly, which exposes a commit that lands late. Out-of-range commits are followed by fetches of the lowest and highest real entries to show that nothing was touched. A sweep is measured in cycles while fetch, commit and a second clear are issued during it. An entry the sweep has already passed must still read zero afterwards, which separates an ignored commit from one that slipped through. A full sweep over all entries after the clear confirms that each type field is free.

// File: rtl/lut_ip_pkg.sv
package lut_ip_pkg;

    localparam int BUS_AW = 8;
    localparam int IDX_FW = 16;

    localparam logic [BUS_AW-1:0] OFS_STATUS = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_CTRL   = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_TBLCMD = 8'h20;
    localparam logic [BUS_AW-1:0] OFS_WORD0  = 8'h34;
    localparam logic [BUS_AW-1:0] OFS_WORD1  = 8'h38;
    localparam logic [BUS_AW-1:0] OFS_WORD2  = 8'h3C;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_state_t;

    typedef struct packed {
        logic [2:0] stage_we;
        logic       fetch;
        logic       commit;
        logic       clear;
        logic       ctrl_we;
        logic       idx_ok;
    } lip_cmd_t;

endpackage

// File: rtl/lut_ip_decode.sv
module lut_ip_decode
    import lut_ip_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              commit_flag,
    input  logic              clear_bit,
    input  logic [IDX_FW-1:0] idx_field,
    input  logic              busy,
    output lip_cmd_t          cmd,
    output logic [IDX_W-1:0]  idx
);

    logic tbl_wr;
    logic ctrl_wr;
    logic in_range;

    assign tbl_wr   = bus_wr && (bus_addr == OFS_TBLCMD);
    assign ctrl_wr  = bus_wr && (bus_addr == OFS_CTRL);
    assign in_range = (32'(idx_field) < DEPTH);
    assign idx      = idx_field[IDX_W-1:0];

    generate
        for (genvar g = 0; g < 3; g++) begin : g_stage
            assign cmd.stage_we[g] = bus_wr && (bus_addr == OFS_WORD0 + BUS_AW'(4 * g));
        end
    endgenerate

    assign cmd.fetch   = tbl_wr && !commit_flag && !busy;
    assign cmd.commit  = tbl_wr && commit_flag && !busy && in_range;
    assign cmd.clear   = ctrl_wr && clear_bit && !busy;
    assign cmd.ctrl_we = ctrl_wr;
    assign cmd.idx_ok  = in_range;

endmodule

// File: rtl/lut_ip_store.sv
module lut_ip_store #(
    parameter int DEPTH   = 1024,
    parameter int ENTRY_W = 72,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [IDX_W-1:0]   raddr,
    output logic [ENTRY_W-1:0] rdata
);

    logic [ENTRY_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/lut_ip_sweep.sv
module lut_ip_sweep
    import lut_ip_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             we,
    output logic [IDX_W-1:0] waddr
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    sweep_state_t     state_q, state_d;
    logic [IDX_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SWEEP;
                    cnt_d   = '0;
                end
            end
            ST_SWEEP: begin
                if (cnt_q == LAST_IDX) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SWEEP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy  = (state_q == ST_SWEEP);
        we    = (state_q == ST_SWEEP);
        waddr = cnt_q;
    end

endmodule

// File: rtl/lut_indirect_port.sv
module lut_indirect_port
    import lut_ip_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int ENTRY_W = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tbl_enable,
    output logic              tbl_busy
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int HI_W  = ENTRY_W - 64;
    localparam logic [4:0] SIZE_UNITS = 5'(DEPTH / 1024);

    lip_cmd_t           cmd;
    logic [IDX_W-1:0]   cmd_idx;
    logic               sw_busy;
    logic               sw_we;
    logic [IDX_W-1:0]   sw_addr;
    logic               ram_we;
    logic [IDX_W-1:0]   ram_wa;
    logic [ENTRY_W-1:0] ram_wd;
    logic [ENTRY_W-1:0] ram_rd;

    logic [HI_W-1:0]    word_hi;
    logic [31:0]        word_mid;
    logic [31:0]        word_lo;
    logic               enable_q;

    lut_ip_decode #(.DEPTH(DEPTH)) u_dec (
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .commit_flag (bus_wdata[31]),
        .clear_bit   (bus_wdata[1]),
        .idx_field   (bus_wdata[IDX_FW-1:0]),
        .busy        (sw_busy),
        .cmd         (cmd),
        .idx         (cmd_idx)
    );

    lut_ip_sweep #(.DEPTH(DEPTH)) u_sweep (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cmd.clear),
        .busy  (sw_busy),
        .we    (sw_we),
        .waddr (sw_addr)
    );

    // The sweep owns the write port while it runs; commits are gated off then.
    assign ram_we = sw_we | cmd.commit;
    assign ram_wa = sw_we ? sw_addr : cmd_idx;
    assign ram_wd = sw_we ? '0 : {word_hi, word_mid, word_lo};

    lut_ip_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_wa),
        .wdata (ram_wd),
        .raddr (cmd_idx),
        .rdata (ram_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_hi  <= '0;
            word_mid <= '0;
            word_lo  <= '0;
        end else if (cmd.fetch) begin
            if (cmd.idx_ok) begin
                word_hi  <= ram_rd[ENTRY_W-1:64];
                word_mid <= ram_rd[63:32];
                word_lo  <= ram_rd[31:0];
            end else begin
                word_hi  <= '0;
                word_mid <= '0;
                word_lo  <= '0;
            end
        end else begin
            if (cmd.stage_we[0]) word_hi  <= bus_wdata[HI_W-1:0];
            if (cmd.stage_we[1]) word_mid <= bus_wdata;
            if (cmd.stage_we[2]) word_lo  <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
        end else if (cmd.ctrl_we) begin
            enable_q <= bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (bus_addr)
                OFS_STATUS: bus_rdata <= {sw_busy, 26'd0, SIZE_UNITS};
                OFS_CTRL:   bus_rdata <= {31'd0, enable_q};
                OFS_WORD0:  bus_rdata <= 32'(word_hi);
                OFS_WORD1:  bus_rdata <= word_mid;
                OFS_WORD2:  bus_rdata <= word_lo;
                default:    bus_rdata <= '0;
            endcase
        end
    end

    assign tbl_enable = enable_q;
    assign tbl_busy   = sw_busy;

endmodule

// File: rtl/lut_ip_checker.sv
module lut_ip_checker
    import lut_ip_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int ENTRY_W = 72,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int HI_W   = ENTRY_W - 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              commit_flag,
    input logic              clear_bit,
    input logic [IDX_FW-1:0] idx_field,
    input logic [31:0]       bus_rdata,
    input logic              busy,
    input logic              ram_we,
    input logic [IDX_W-1:0]  ram_wa,
    input logic [HI_W-1:0]   word_hi,
    input logic [31:0]       word_mid,
    input logic [31:0]       word_lo
);

    logic [IDX_W:0] busy_len;
    logic           tbl_cmd;
    logic           idx_big;

    assign tbl_cmd = bus_wr && (bus_addr == OFS_TBLCMD);
    assign idx_big = (32'(idx_field) >= DEPTH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    a_r6_sweep_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == (IDX_W+1)'(DEPTH));

    a_r6_clear_start: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL && clear_bit && !busy) |=> busy);

    a_r4_commit_write: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_cmd && commit_flag && !idx_big && !busy) |-> (ram_we && ram_wa == IDX_W'(idx_field)));

    a_r5_oob_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_cmd && commit_flag && idx_big && !busy) |-> !ram_we);

    a_r5_oob_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_cmd && !commit_flag && idx_big && !busy) |=>
            (word_hi == '0 && word_mid == '0 && word_lo == '0));

    a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_cmd && busy) |=> ($stable(word_hi) && $stable(word_mid) && $stable(word_lo)));

    a_r2_word0_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_WORD0) |=> bus_rdata[31:HI_W] == '0);

    a_r10_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_TBLCMD) |=> bus_rdata == '0);

endmodule

bind lut_indirect_port lut_ip_checker #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .commit_flag (bus_wdata[31]),
    .clear_bit   (bus_wdata[1]),
    .idx_field   (bus_wdata[15:0]),
    .bus_rdata   (bus_rdata),
    .busy        (sw_busy),
    .ram_we      (ram_we),
    .ram_wa      (ram_wa),
    .word_hi     (word_hi),
    .word_mid    (word_mid),
    .word_lo     (word_lo)
);

// File: tb/lut_indirect_port_test.sv
`timescale 1ns/1ps
module lut_indirect_port_test;

    localparam int DEPTH   = 1024;
    localparam int ENTRY_W = 72;
    localparam int HI_W    = ENTRY_W - 64;
    localparam logic [31:0] HI_MASK = (32'd1 << HI_W) - 32'd1;

    localparam logic [7:0] A_STAT = 8'h04;
    localparam logic [7:0] A_CTRL = 8'h08;
    localparam logic [7:0] A_CMD  = 8'h20;
    localparam logic [7:0] A_W0   = 8'h34;
    localparam logic [7:0] A_W1   = 8'h38;
    localparam logic [7:0] A_W2   = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tbl_enable;
    logic        tbl_busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lut_indirect_port #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tbl_enable(tbl_enable), .tbl_busy(tbl_busy)
    );

    function automatic logic [31:0] pat0(int i);
        return (32'(i) * 32'd13 + 32'd1) & HI_MASK;
    endfunction
    function automatic logic [31:0] pat1(int i);
        return 32'(i) * 32'h9E37_79B9 + 32'd7;
    endfunction
    function automatic logic [31:0] pat2(int i);
        return (32'(i) * 32'h0100_0193) ^ 32'hA5A5_0000;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic fetch(int idx, output logic [31:0] w0, output logic [31:0] w1,
                         output logic [31:0] w2);
        wr(A_CMD, 32'(idx) & 32'h0000_FFFF);
        rd(A_W0, w0);
        rd(A_W1, w1);
        rd(A_W2, w2);
    endtask

    task automatic wait_idle(inout int n);
        int guard = 0;
        while (tbl_busy && guard < 4 * DEPTH) begin
            n++; guard++;
            @(posedge clk); #1;
        end
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, w0, w1, w2;
        int n;

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 enable after reset", 32'(tbl_enable), 32'd0);
        check("R1 busy after reset", 32'(tbl_busy), 32'd1);
        n = 0;
        wait_idle(n);
        check("R6 reset sweep length", 32'(n), 32'(DEPTH));
        fetch(0, w0, w1, w2);
        check("R1 entry 0 word0", w0, 32'd0);
        check("R1 entry 0 word1", w1, 32'd0);
        check("R1 entry 0 word2", w2, 32'd0);
        fetch(DEPTH - 1, w0, w1, w2);
        check("R1 last entry word1", w1, 32'd0);

        // R8 status
        rd(A_STAT, d);
        check("R8 size units", d & 32'h1F, 32'(DEPTH / 1024));
        check("R6 status busy clear", d[31], 1'b0);

        // R9 control
        wr(A_CTRL, 32'h1);
        check("R9 enable output", 32'(tbl_enable), 32'd1);
        rd(A_CTRL, d);
        check("R9 control readback", d, 32'h1);
        wr(A_CTRL, 32'h0);
        check("R9 enable cleared", 32'(tbl_enable), 32'd0);

        // R10 unmapped and command register read zero
        rd(A_CMD, d);  check("R10 command reads zero", d, 32'd0);
        rd(8'h00, d);  check("R10 offset 0x00", d, 32'd0);
        rd(8'h10, d);  check("R10 offset 0x10", d, 32'd0);
        rd(8'h40, d);  check("R10 offset 0x40", d, 32'd0);

        // R2 staging words
        wr(A_W0, 32'hFFFF_FFFF);
        wr(A_W1, 32'h1234_5678);
        wr(A_W2, 32'h9ABC_DEF0);
        rd(A_W0, d); check("R2 word0 masked", d, HI_MASK);
        rd(A_W1, d); check("R2 word1", d, 32'h1234_5678);
        rd(A_W2, d); check("R2 word2", d, 32'h9ABC_DEF0);

        // R4 commit every entry
        for (int i = 0; i < DEPTH; i++) begin
            wr(A_W0, pat0(i) | 32'hFF00_0000);
            wr(A_W1, pat1(i));
            wr(A_W2, pat2(i));
            wr(A_CMD, 32'h8000_0000 | 32'(i));
        end
        // R3 fetch every entry, first one straight after its commit
        for (int i = DEPTH - 1; i >= 0; i--) begin
            fetch(i, w0, w1, w2);
            check("R3 R4 word0", w0, pat0(i));
            check("R3 R4 word1", w1, pat1(i));
            check("R3 R4 word2", w2, pat2(i));
        end

        // R5 out-of-range commit and fetch
        wr(A_W0, 32'h55); wr(A_W1, 32'h5555_5555); wr(A_W2, 32'hAAAA_AAAA);
        wr(A_CMD, 32'h8000_0000 | 32'(DEPTH));
        wr(A_CMD, 32'h8000_FFFF);
        fetch(0, w0, w1, w2);
        check("R5 entry 0 untouched w1", w1, pat1(0));
        check("R5 entry 0 untouched w2", w2, pat2(0));
        fetch(DEPTH - 1, w0, w1, w2);
        check("R5 last entry untouched w0", w0, pat0(DEPTH - 1));
        check("R5 last entry untouched w1", w1, pat1(DEPTH - 1));
        fetch(DEPTH, w0, w1, w2);
        check("R5 oob fetch word0", w0, 32'd0);
        check("R5 oob fetch word1", w1, 32'd0);
        check("R5 oob fetch word2", w2, 32'd0);
        wr(A_W1, 32'h7777_7777);
        fetch(32'hFFFF, w0, w1, w2);
        check("R5 oob fetch max index", w1, 32'd0);

        // R7 activity during a sweep
        wr(A_W0, 32'h3C); wr(A_W1, 32'hCAFE_F00D); wr(A_W2, 32'h0BAD_BEEF);
        wr(A_CTRL, 32'h2);
        n = 0;
        check("R6 busy after clear", 32'(tbl_busy), 32'd1);
        wr(A_CMD, 32'd3);                    n++;
        rd(A_W0, d); n++; check("R7 fetch ignored word0", d, 32'h3C);
        rd(A_W1, d); n++; check("R7 fetch ignored word1", d, 32'hCAFE_F00D);
        rd(A_W2, d); n++; check("R7 fetch ignored word2", d, 32'h0BAD_BEEF);
        rd(A_STAT, d); n++; check("R6 status busy bit", d[31], 1'b1);
        wr(A_CMD, 32'h8000_0000);            n++;
        wr(A_CTRL, 32'h2);                   n++;
        wait_idle(n);
        check("R7 R6 sweep length not restarted", 32'(n), 32'(DEPTH));
        fetch(0, w0, w1, w2);
        check("R7 commit during sweep ignored", w1 | w2 | w0, 32'd0);

        // R6 every entry free after clear
        for (int i = 0; i < DEPTH; i++) begin
            fetch(i, w0, w1, w2);
            check("R6 type free", (w1 >> 28) & 32'h3, 32'd0);
            check("R6 entry zero", w0 | w1 | w2, 32'd0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule